// File: doc/BRIEF.md
# Segmented Memory Window Translator

This block owns three 16-bit mapping registers (two fetch maps and one data map) and uses them to turn a processor's 16-bit data address and its word-granular program counter into a physical destination. Every destination is one of four targets: on-chip data RAM, instruction memory, a 128 KB unified-memory segment, or the I/O page. For each of the two address streams it reports the target, a byte offset inside that target, the unified segment number, and a bus-error flag.

The data side has a 16 KB window that is steered by the data map either into instruction memory or into part of a unified segment. The fetch side picks one of the two fetch maps from the top bit of the byte address and sends the fetch either to instruction memory or to a whole unified segment. A 128-bit presence vector, driven by whatever allocates the segments, tells the block which unified segments exist; touching an absent one is a bus error. Both translations are combinational and run side by side in every cycle; the map registers change on a write strobe and the new value steers translations from the following cycle on.

Top module: `memwin_xlate`

## Requirements
- R1: After a synchronous active-low reset both fetch maps hold 0x1000 and the data map holds 0x0000, so fetches go to instruction memory and the data window goes to unified segment 0.
- R2: A data address with bit 15 clear (0x0000 to 0x7FFF) selects data RAM (target code 0) with offset equal to the address and no error.
- R3: A data address in 0x8000 to 0xBFFF with data-map bit 12 set selects instruction memory (target code 1) at offset {data-map[3:0], address[13:0]}.
- R4: A data address in 0x8000 to 0xBFFF with data-map bit 12 clear selects unified memory (target code 2), segment data-map[9:3], offset {data-map[2:0], address[13:0]}.
- R5: A data address of 0xC000 or above selects I/O (target code 3) with offset equal to the address; only 0xFF00 to 0xFF0F is legal there, any other address raises the data error.
- R6: The fetch byte address is {pc, 2'b00}; its bit 17 (pc[15]) set selects fetch map 1, clear selects fetch map 0.
- R7: When the selected fetch map has bit 12 set the fetch selects instruction memory with offset equal to the full 18-bit byte address.
- R8: When the selected fetch map has bit 12 clear the fetch selects unified memory, segment map[7:0], offset byte-address[16:0]; a segment field of 128 or more is a fetch error.
- R9: A unified-memory access whose segment has its presence bit clear raises the error of that side.
- R10: A map write (select 0 = fetch map 0, 1 = fetch map 1, 2 = data map, 3 = no register) changes only the selected register and steers translation from the next cycle; the cycle of the write still uses the old value.
- R11: An error flag is low whenever its request input is low, and the segment output is 0 whenever the target is not unified memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_sel | input | 2 | Register select: 0 fetch map 0, 1 fetch map 1, 2 data map, 3 none |
| map_wr_data | input | 16 | Value written to the selected map |
| seg_present | input | 128 | One bit per unified segment, set when the segment exists |
| d_req | input | 1 | Data access valid, qualifies d_err |
| d_addr | input | 16 | Data byte address |
| f_req | input | 1 | Fetch valid, qualifies f_err |
| f_pc | input | 16 | Program counter in 32-bit words |
| d_tgt | output | 2 | Data target: 0 data RAM, 1 instruction memory, 2 unified, 3 I/O |
| d_off | output | 18 | Data byte offset within the target |
| d_seg | output | 7 | Data unified segment number |
| d_err | output | 1 | Data bus error |
| f_tgt | output | 2 | Fetch target, same coding as d_tgt |
| f_off | output | 18 | Fetch byte offset within the target |
| f_seg | output | 7 | Fetch unified segment number |
| f_err | output | 1 | Fetch bus error |

## Verification
The two translators share the map register file and the presence vector, so a data access and a fetch can land in unified memory in the same cycle while a map write is also pending. The bench drives both streams every cycle, with random map writes interleaved, and places some cases so that the data window and the fetch map name the same segment or a write targets the map in use that very cycle. Each side is judged separately against a bench model that applies the write only after the edge, so a result that used the new value early, or that mixed one side's segment into the other's error, shows up as a mismatch.

// File: rtl/memwin_pkg.sv
// Shared widths, target codes and field positions for the memory window
// translator. Assumes a 16-bit data address and a 16-bit word PC.
package memwin_pkg;

    localparam int ADDR_W    = 16;                  // data address width
    localparam int PC_W      = 16;                  // word PC width
    localparam int MAP_W     = 16;                  // map register width
    localparam int SEG_COUNT = 128;                 // unified segments
    localparam int SEG_W     = $clog2(SEG_COUNT);   // segment index width
    localparam int UNI_OFF_W = 17;                  // 128 KB segment offset
    localparam int OFF_W     = UNI_OFF_W + 1;       // widest target offset
    localparam int WIN_W     = 14;                  // 16 KB window offset
    localparam int FSEG_FLD_W = 8;                  // fetch map segment field
    localparam int MAP_CNT   = 3;                   // number of map registers

    // bit in every map that routes to instruction memory
    localparam int MAP_IMEM_BIT = 12;

    // data map field positions
    localparam int DMAP_IBLK_LO = 0;   // instruction-memory block, 4 bits
    localparam int DMAP_IBLK_W  = 4;
    localparam int DMAP_SUB_LO  = 0;   // 16 KB slot inside a segment, 3 bits
    localparam int DMAP_SUB_W   = 3;
    localparam int DMAP_SEG_LO  = 3;   // segment number, 7 bits

    // I/O page that is accepted
    localparam logic [ADDR_W-5:0] IO_OK_PAGE = 12'hFF0;

    // reset values of the maps
    localparam logic [MAP_W-1:0] FMAP_RST = 16'h1000;
    localparam logic [MAP_W-1:0] DMAP_RST = 16'h0000;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IMEM = 2'd1,
        TGT_UNI  = 2'd2,
        TGT_IO   = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        SEL_FMAP0 = 2'd0,
        SEL_FMAP1 = 2'd1,
        SEL_DMAP  = 2'd2,
        SEL_NONE  = 2'd3
    } map_sel_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [OFF_W-1:0] off;
        logic [SEG_W-1:0] seg;
        logic             err;
    } xlate_t;

endpackage

// File: rtl/memwin_maps.sv
// Map register file: two fetch maps and one data map.
// Assumes one write per cycle; a write is visible on the outputs after the
// clock edge that captures it. Reset is synchronous and active low.
module memwin_maps
    import memwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [MAP_W-1:0] wr_data,
    output logic [MAP_W-1:0] fmap0,
    output logic [MAP_W-1:0] fmap1,
    output logic [MAP_W-1:0] dmap
);

    logic [MAP_W-1:0] regs_q [MAP_CNT];

    // reset value of register i
    function automatic logic [MAP_W-1:0] rst_val(input int i);
        return (i == int'(SEL_DMAP)) ? DMAP_RST : FMAP_RST;
    endfunction

    for (genvar i = 0; i < MAP_CNT; i++) begin : g_reg
        // one map register: reset, or capture when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= rst_val(i);
            else if (wr_en && (wr_sel == 2'(i)))
                regs_q[i] <= wr_data;
        end
    end

    // drive named outputs from the register array
    always_comb begin
        fmap0 = regs_q[SEL_FMAP0];
        fmap1 = regs_q[SEL_FMAP1];
        dmap  = regs_q[SEL_DMAP];
    end

endmodule

// File: rtl/memwin_dwin.sv
// Data address translator. Splits the 16-bit data space into direct RAM,
// a 16 KB steerable window and the I/O page. Purely combinational.
// Assumes the presence vector is stable for the cycle.
module memwin_dwin
    import memwin_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 req,
    input  logic [MAP_W-1:0]     dmap,
    input  logic [SEG_COUNT-1:0] present,
    output xlate_t               res
);

    logic [1:0]           region;
    logic [WIN_W-1:0]     win_off;
    logic [SEG_W-1:0]     win_seg;
    logic                 to_imem;
    logic                 seg_ok;
    logic                 io_ok;

    // decode address fields and map fields
    always_comb begin
        region  = addr[ADDR_W-1 -: 2];
        win_off = addr[WIN_W-1:0];
        win_seg = dmap[DMAP_SEG_LO +: SEG_W];
        to_imem = dmap[MAP_IMEM_BIT];
        seg_ok  = present[win_seg];
        io_ok   = (addr[ADDR_W-1:4] == IO_OK_PAGE);
    end

    // select target, offset, segment and fault per region
    always_comb begin
        res = '{tgt: TGT_DRAM, off: '0, seg: '0, err: 1'b0};
        unique case (region)
            2'b00, 2'b01: begin
                res.tgt = TGT_DRAM;
                res.off = OFF_W'(addr);
            end
            2'b10: begin
                if (to_imem) begin
                    res.tgt = TGT_IMEM;
                    res.off = {dmap[DMAP_IBLK_LO +: DMAP_IBLK_W], win_off};
                end else begin
                    res.tgt = TGT_UNI;
                    res.off = OFF_W'({dmap[DMAP_SUB_LO +: DMAP_SUB_W], win_off});
                    res.seg = win_seg;
                    res.err = req && !seg_ok;
                end
            end
            default: begin
                res.tgt = TGT_IO;
                res.off = OFF_W'(addr);
                res.err = req && !io_ok;
            end
        endcase
    end

endmodule

// File: rtl/memwin_fwin.sv
// Fetch translator. Forms the byte address from the word PC, picks one of
// two fetch maps by byte-address bit 17 and routes to instruction memory or
// a unified segment. Purely combinational.
module memwin_fwin
    import memwin_pkg::*;
(
    input  logic [PC_W-1:0]      pc,
    input  logic                 req,
    input  logic [MAP_W-1:0]     fmap0,
    input  logic [MAP_W-1:0]     fmap1,
    input  logic [SEG_COUNT-1:0] present,
    output xlate_t               res
);

    localparam int BYTE_W = PC_W + 2;

    logic [BYTE_W-1:0]     byte_addr;
    logic [MAP_W-1:0]      map_sel;
    logic [FSEG_FLD_W-1:0] seg_fld;
    logic [SEG_W-1:0]      seg_idx;
    logic                  in_range;
    logic                  seg_ok;

    // byte address and fetch map selection
    always_comb begin
        byte_addr = {pc, 2'b00};
        map_sel   = byte_addr[BYTE_W-1] ? fmap1 : fmap0;
        seg_fld   = map_sel[FSEG_FLD_W-1:0];
        in_range  = ({1'b0, seg_fld} < (FSEG_FLD_W+1)'(SEG_COUNT));
        seg_idx   = seg_fld[SEG_W-1:0];
        seg_ok    = in_range && present[seg_idx];
    end

    // route to instruction memory or a unified segment
    always_comb begin
        res = '{tgt: TGT_IMEM, off: '0, seg: '0, err: 1'b0};
        if (map_sel[MAP_IMEM_BIT]) begin
            res.tgt = TGT_IMEM;
            res.off = OFF_W'(byte_addr);
        end else begin
            res.tgt = TGT_UNI;
            res.off = OFF_W'(byte_addr[UNI_OFF_W-1:0]);
            res.seg = seg_idx;
            res.err = req && !seg_ok;
        end
    end

endmodule

// File: rtl/memwin_xlate.sv
// Top of the segmented memory window translator. Holds the map registers
// and runs the data and fetch translations in parallel every cycle.
// Assumes the caller samples the outputs in the same cycle as the inputs.
module memwin_xlate
    import memwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_wr_en,
    input  logic [1:0]           map_wr_sel,
    input  logic [MAP_W-1:0]     map_wr_data,
    input  logic [SEG_COUNT-1:0] seg_present,
    input  logic                 d_req,
    input  logic [ADDR_W-1:0]    d_addr,
    input  logic                 f_req,
    input  logic [PC_W-1:0]      f_pc,
    output logic [1:0]           d_tgt,
    output logic [OFF_W-1:0]     d_off,
    output logic [SEG_W-1:0]     d_seg,
    output logic                 d_err,
    output logic [1:0]           f_tgt,
    output logic [OFF_W-1:0]     f_off,
    output logic [SEG_W-1:0]     f_seg,
    output logic                 f_err
);

    logic [MAP_W-1:0] fmap0, fmap1, dmap;
    xlate_t           d_res, f_res;

    memwin_maps u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_sel  (map_wr_sel),
        .wr_data (map_wr_data),
        .fmap0   (fmap0),
        .fmap1   (fmap1),
        .dmap    (dmap)
    );

    memwin_dwin u_dwin (
        .addr    (d_addr),
        .req     (d_req),
        .dmap    (dmap),
        .present (seg_present),
        .res     (d_res)
    );

    memwin_fwin u_fwin (
        .pc      (f_pc),
        .req     (f_req),
        .fmap0   (fmap0),
        .fmap1   (fmap1),
        .present (seg_present),
        .res     (f_res)
    );

    // unpack translation results onto the ports
    always_comb begin
        d_tgt = d_res.tgt;
        d_off = d_res.off;
        d_seg = d_res.seg;
        d_err = d_res.err;
        f_tgt = f_res.tgt;
        f_off = f_res.off;
        f_seg = f_res.seg;
        f_err = f_res.err;
    end

endmodule

// File: rtl/memwin_chk.sv
// Property checker for memwin_xlate, attached by bind below.
module memwin_chk
    import memwin_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 map_wr_en,
    input logic [1:0]           map_wr_sel,
    input logic [MAP_W-1:0]     map_wr_data,
    input logic [SEG_COUNT-1:0] seg_present,
    input logic                 d_req,
    input logic [ADDR_W-1:0]    d_addr,
    input logic                 f_req,
    input logic [PC_W-1:0]      f_pc,
    input logic [1:0]           d_tgt,
    input logic [OFF_W-1:0]     d_off,
    input logic [SEG_W-1:0]     d_seg,
    input logic                 d_err,
    input logic [1:0]           f_tgt,
    input logic [OFF_W-1:0]     f_off,
    input logic [SEG_W-1:0]     f_seg,
    input logic                 f_err
);

    assert_dram_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !d_addr[ADDR_W-1] |-> (d_tgt == TGT_DRAM && d_off == OFF_W'(d_addr) && !d_err));

    assert_io_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_addr[ADDR_W-1 -: 2] == 2'b11 && d_addr[ADDR_W-1:4] != IO_OK_PAGE) |-> d_err);

    assert_fetch_imem_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_tgt == TGT_IMEM) |-> (f_off == {f_pc, 2'b00}));

    assert_data_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_tgt == TGT_UNI && !seg_present[d_seg]) |-> d_err);

    assert_fetch_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_req && f_tgt == TGT_UNI && !seg_present[f_seg]) |-> f_err);

    assert_dmap_write_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr_en && map_wr_sel == SEL_DMAP && map_wr_data[MAP_IMEM_BIT])
        |=> (d_addr[ADDR_W-1 -: 2] != 2'b10 || d_tgt == TGT_IMEM));

    assert_err_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_req |-> !d_err) and (!f_req |-> !f_err));

    assert_seg_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (d_tgt != TGT_UNI |-> d_seg == '0) and (f_tgt != TGT_UNI |-> f_seg == '0));

endmodule

bind memwin_xlate memwin_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_wr_en   (map_wr_en),
    .map_wr_sel  (map_wr_sel),
    .map_wr_data (map_wr_data),
    .seg_present (seg_present),
    .d_req       (d_req),
    .d_addr      (d_addr),
    .f_req       (f_req),
    .f_pc        (f_pc),
    .d_tgt       (d_tgt),
    .d_off       (d_off),
    .d_seg       (d_seg),
    .d_err       (d_err),
    .f_tgt       (f_tgt),
    .f_off       (f_off),
    .f_seg       (f_seg),
    .f_err       (f_err)
);

// File: tb/sim_memwin_xlate.sv
module sim_memwin_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 400;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         map_wr_en = 1'b0;
    logic [1:0]   map_wr_sel = 2'd3;
    logic [15:0]  map_wr_data = '0;
    logic [127:0] seg_present = '0;
    logic         d_req = 1'b0;
    logic [15:0]  d_addr = '0;
    logic         f_req = 1'b0;
    logic [15:0]  f_pc = '0;
    logic [1:0]   d_tgt, f_tgt;
    logic [17:0]  d_off, f_off;
    logic [6:0]   d_seg, f_seg;
    logic         d_err, f_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench copy of the map registers
    logic [15:0] m_f0, m_f1, m_d;

    memwin_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .map_wr_en(map_wr_en), .map_wr_sel(map_wr_sel), .map_wr_data(map_wr_data),
        .seg_present(seg_present),
        .d_req(d_req), .d_addr(d_addr), .f_req(f_req), .f_pc(f_pc),
        .d_tgt(d_tgt), .d_off(d_off), .d_seg(d_seg), .d_err(d_err),
        .f_tgt(f_tgt), .f_off(f_off), .f_seg(f_seg), .f_err(f_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected data result {tgt, off, seg, err} per R2..R5, R9, R11
    task automatic exp_data(input logic [15:0] a, input logic r, output logic [27:0] v,
                            output string tag);
        logic [6:0] s;
        if (!a[15]) begin
            v = {2'd0, 2'b00, a, 7'd0, 1'b0}; tag = "R2";
        end else if (a[15:14] == 2'b10) begin
            if (m_d[12]) begin
                v = {2'd1, m_d[3:0], a[13:0], 7'd0, 1'b0}; tag = "R3";
            end else begin
                s = m_d[9:3];
                v = {2'd2, 1'b0, m_d[2:0], a[13:0], s, r & ~seg_present[s]};
                tag = seg_present[s] ? "R4" : "R9";
            end
        end else begin
            v = {2'd3, 2'b00, a, 7'd0, r & (a[15:4] != 12'hFF0)}; tag = "R5";
        end
    endtask

    // expected fetch result per R6..R9
    task automatic exp_fetch(input logic [15:0] p, input logic r, output logic [27:0] v,
                             output string tag);
        logic [17:0] b;
        logic [15:0] m;
        b = {p, 2'b00};
        m = b[17] ? m_f1 : m_f0;
        if (m[12]) begin
            v = {2'd1, b, 7'd0, 1'b0}; tag = "R7";
        end else begin
            v = {2'd2, 1'b0, b[16:0], m[6:0], r & (m[7] | ~seg_present[m[6:0]])};
            tag = (m[7] || !seg_present[m[6:0]]) ? "R9" : "R8";
        end
    endtask

    task automatic check(input string tag, input string side, input logic [27:0] act,
                         input logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s side: actual tgt/off/seg/err=%h expected %h", tag, side, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, then model the write at the edge
    task automatic step(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                        input logic [15:0] da, input logic dr, input logic [15:0] p,
                        input logic fr, input string tag);
        logic [27:0] ed, ef;
        string td, tf;
        @(negedge clk);
        map_wr_en = we; map_wr_sel = ws; map_wr_data = wd;
        d_addr = da; d_req = dr; f_pc = p; f_req = fr;
        #1;
        exp_data(da, dr, ed, td);
        exp_fetch(p, fr, ef, tf);
        check((tag != "") ? tag : td, "data", {d_tgt, d_off, d_seg, d_err}, ed);
        check((tag != "") ? tag : tf, "fetch", {f_tgt, f_off, f_seg, f_err}, ef);
        @(posedge clk);
        if (we) begin
            case (ws)
                2'd0: m_f0 = wd;
                2'd1: m_f1 = wd;
                2'd2: m_d  = wd;
                default: ;
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        seg_present = {32'hA5A5_0F0F, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_000D};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        m_f0 = 16'h1000; m_f1 = 16'h1000; m_d = 16'h0000;

        // R1: reset values steer fetch to imem and window to segment 0
        step(0, 2'd3, 16'h0, 16'h8004, 1, 16'h1234, 1, "R1");
        step(0, 2'd3, 16'h0, 16'h0123, 1, 16'h8002, 1, "R1");
        // R2 and R5 directed corners
        step(0, 2'd3, 16'h0, 16'h7FFF, 1, 16'h0000, 1, "R2");
        step(0, 2'd3, 16'h0, 16'hFF0F, 1, 16'h0000, 1, "R5");
        step(0, 2'd3, 16'h0, 16'hFF10, 1, 16'h0000, 1, "R5");
        step(0, 2'd3, 16'h0, 16'hC000, 1, 16'h0000, 1, "R5");
        // R10: dmap write; same cycle still old value, next cycle new
        step(1, 2'd2, 16'h1005, 16'h8010, 1, 16'h0001, 1, "R10");
        step(0, 2'd3, 16'h0, 16'h8010, 1, 16'h0001, 1, "R10");
        // R10: select 3 writes nothing
        step(1, 2'd3, 16'h0000, 16'hBFFF, 1, 16'h0001, 1, "R10");
        step(0, 2'd3, 16'h0, 16'hBFFF, 1, 16'h0001, 1, "R3");
        // R6: fetch map 1 chosen by pc[15]; segment 3 present
        step(1, 2'd1, 16'h0003, 16'h0000, 1, 16'h8001, 1, "R10");
        step(0, 2'd3, 16'h0, 16'h0000, 1, 16'h8001, 1, "R6");
        step(0, 2'd3, 16'h0, 16'h0000, 1, 16'h7FFF, 1, "R6");
        // R8: segment field beyond 127 faults
        step(1, 2'd1, 16'h0085, 16'h0000, 1, 16'hC000, 1, "R10");
        step(0, 2'd3, 16'h0, 16'h0000, 1, 16'hC000, 1, "R8");
        // R11: no request, no error even with faulting addresses
        step(0, 2'd3, 16'h0, 16'hC000, 0, 16'hC000, 0, "R11");
        // R4/R9: window to absent segment 4 (bit 4 of present clear)
        step(1, 2'd2, 16'h0027, 16'h9234, 1, 16'h0000, 1, "R10");
        step(0, 2'd3, 16'h0, 16'h9234, 1, 16'h0000, 1, "R9");
        // R9: data window and fetch on the same segment in one cycle
        step(1, 2'd0, 16'h0004, 16'h8000, 1, 16'h0010, 1, "R10");
        step(0, 2'd3, 16'h0, 16'h8000, 1, 16'h0010, 1, "R9");

        // constrained random mix
        for (int i = 0; i < N_RAND; i++) begin
            logic [15:0] wd, da, p;
            logic [1:0]  ws;
            logic        we;
            we = ($urandom % 3) == 0;
            ws = 2'($urandom);
            wd = 16'($urandom) & 16'h10FF;
            if (($urandom % 8) == 0) wd[7] = 1'b1;
            da = 16'($urandom);
            if (($urandom % 4) == 0) da = {12'hFF0, 4'($urandom)};
            p  = 16'($urandom);
            if (($urandom % 16) == 0)
                seg_present = {$urandom, $urandom, $urandom, $urandom};
            step(we, ws, wd, da, 1'($urandom), p, 1'($urandom), "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule